// File: doc/BRIEF.md
# Inter-core mailbox bank with set and clear windows

The block holds a bank of 32-bit mailboxes, a fixed number per processor core (four per core and four cores by default), through which cores signal one another. A sender posts bits into a mailbox by writing to that mailbox's set window; the written word is ORed into the stored value. The receiver reads the mailbox through its clear window and acknowledges by writing back the bits it has handled, which removes exactly those bits. A mailbox counts as pending whenever any bit is set.

Each core has an 8-bit delivery control register. For every mailbox of that core it can choose normal interrupt delivery, fast interrupt delivery, or no delivery. Fast delivery wins when both are enabled. The block presents per-mailbox pending, normal-interrupt source and fast-interrupt source vectors, plus per-core interrupt lines. Merging these with other interrupt sources happens outside the block. Access is through a simple 32-bit word register port with a one-cycle registered read.

Top module: `mbx_bank`

## Requirements
- R1: A write to address 0x80 + 4*i, where i = 4*core + mailbox, ORs the write data into mailbox i. Mailbox i's pending bit is visible on the cycle after the write.
- R2: A write to address 0xC0 + 4*i clears, in mailbox i, every bit that is 1 in the write data. All other bits are kept.
- R3: A read of address 0xC0 + 4*i returns the contents of mailbox i on `rdata` one cycle after `rd_en`. Reading does not change the mailbox.
- R4: A read anywhere in the set window (0x80 to 0xBF) returns zero.
- R5: `mbox_pending[i]` is 1 exactly when mailbox i is nonzero.
- R6: The control register of core c sits at 0x50 + 4*c. Only write-data bits 7:0 are stored, and a read returns them zero-extended.
- R7: Control bit 4+n set sends pending mailbox n of that core to `fiq_src` and not to `irq_src`. This holds even when control bit n is also set.
- R8: Control bit n set with bit 4+n clear sends pending mailbox n to `irq_src`. With both bits clear, the mailbox reaches neither vector.
- R9: `core_irq[c]` and `core_fiq[c]` are the OR of core c's four bits in `irq_src` and `fiq_src`. Bit 4*c+n of each vector belongs to mailbox n of core c.
- R10: While `rst_n` is low, all mailboxes and control registers are zero, so every output vector is zero. After `rst_n` rises, the block accepts accesses from the third rising edge on.
- R11: Mailbox contents and outputs change only on the clock edge that takes a write.
- R12: A write to an address outside the set, clear and control windows changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 8 | Byte address of the 32-bit word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after `rd_en` |
| mbox_pending | output | 16 | One bit per mailbox, set while the mailbox is nonzero |
| irq_src | output | 16 | Pending mailboxes routed to normal interrupt |
| fiq_src | output | 16 | Pending mailboxes routed to fast interrupt |
| core_irq | output | 4 | Per-core normal interrupt contribution |
| core_fiq | output | 4 | Per-core fast interrupt contribution |

## Verification
The bench repeats sets into a mailbox that already holds data. A design that overwrote instead of ORing would lose the earlier bits. It clears a subset of bits and then reads back: a design that cleared the whole word on any clear write, or on a read, would show zero where bits must remain. It programs both delivery bits for one mailbox, so a design with the priority reversed would raise the normal line. It writes a control value wider than eight bits, so a design without truncation would read back the high bits. It also writes to an unmapped address and probes reads in the set window, which expose a loose address decode.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Which register window an access falls in.
  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_SET  = 2'd1,
    WIN_CLR  = 2'd2,
    WIN_CTRL = 2'd3
  } win_e;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
  parameter int ADDR_W    = 8,
  parameter int NMBX      = 16,
  parameter int NCORE     = 4,
  parameter int SET_BASE  = 'h80,
  parameter int CLR_BASE  = 'hC0,
  parameter int CTRL_BASE = 'h50,
  localparam int IDX_W    = $clog2(NMBX),
  localparam int CORE_W   = $clog2(NCORE)
) (
  input  logic [ADDR_W-1:0] addr,
  output mbx_pkg::win_e     win,
  output logic [IDX_W-1:0]  idx,
  output logic [CORE_W-1:0] core_sel
);
  import mbx_pkg::*;

  localparam int SET_END  = SET_BASE + 4 * NMBX;
  localparam int CLR_END  = CLR_BASE + 4 * NMBX;
  localparam int CTRL_END = CTRL_BASE + 4 * NCORE;

  logic [31:0] a32;

  always_comb begin
    a32      = 32'(addr);
    win      = WIN_NONE;
    idx      = '0;
    core_sel = '0;
    if (a32 >= 32'(CLR_BASE) && a32 < 32'(CLR_END)) begin
      win = WIN_CLR;
      idx = IDX_W'((a32 - 32'(CLR_BASE)) >> 2);
    end else if (a32 >= 32'(SET_BASE) && a32 < 32'(SET_END)) begin
      win = WIN_SET;
      idx = IDX_W'((a32 - 32'(SET_BASE)) >> 2);
    end else if (a32 >= 32'(CTRL_BASE) && a32 < 32'(CTRL_END)) begin
      win      = WIN_CTRL;
      core_sel = CORE_W'((a32 - 32'(CTRL_BASE)) >> 2);
    end
  end

endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int NMBX   = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NMBX)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   set_en,
  input  logic                   clr_en,
  input  logic [IDX_W-1:0]       idx,
  input  logic [DATA_W-1:0]      wdata,
  output logic [NMBX*DATA_W-1:0] mbox_flat
);

  for (genvar i = 0; i < NMBX; i++) begin : g_mbox
    logic [DATA_W-1:0] mbox_q, mbox_d;
    logic              hit, mbox_en;

    always_comb begin
      hit     = (idx == IDX_W'(i));
      mbox_en = hit && (set_en || clr_en);
      mbox_d  = mbox_q;
      if (set_en)      mbox_d = mbox_q | wdata;
      else if (clr_en) mbox_d = mbox_q & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mbox_q <= '0;
      else if (mbox_en) mbox_q <= mbox_d;
    end

    assign mbox_flat[i*DATA_W +: DATA_W] = mbox_q;
  end

endmodule

// File: rtl/mbx_route.sv
module mbx_route #(
  parameter int NCORE  = 4,
  parameter int MPC    = 4,
  localparam int NMBX   = NCORE * MPC,
  localparam int CTRL_W = 2 * MPC
) (
  input  logic [NMBX-1:0]         pending,
  input  logic [NCORE*CTRL_W-1:0] ctrl_flat,
  output logic [NMBX-1:0]         irq_src,
  output logic [NMBX-1:0]         fiq_src,
  output logic [NCORE-1:0]        core_irq,
  output logic [NCORE-1:0]        core_fiq
);

  for (genvar c = 0; c < NCORE; c++) begin : g_core
    logic [CTRL_W-1:0] ctl;
    logic [MPC-1:0]    pend, irq_en, fiq_en;

    always_comb begin
      ctl    = ctrl_flat[c*CTRL_W +: CTRL_W];
      pend   = pending[c*MPC +: MPC];
      irq_en = ctl[MPC-1:0];
      fiq_en = ctl[CTRL_W-1:MPC];
    end

    // Fast delivery wins over normal delivery.
    assign fiq_src[c*MPC +: MPC] = pend & fiq_en;
    assign irq_src[c*MPC +: MPC] = pend & irq_en & ~fiq_en;
    assign core_fiq[c]           = |(pend & fiq_en);
    assign core_irq[c]           = |(pend & irq_en & ~fiq_en);
  end

endmodule

// File: rtl/mbx_bank.sv
module mbx_bank #(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 32,
  parameter int NUM_CORES    = 4,
  parameter int MBX_PER_CORE = 4,
  parameter int SET_BASE     = 'h80,
  parameter int CLR_BASE     = 'hC0,
  parameter int CTRL_BASE    = 'h50,
  localparam int NMBX   = NUM_CORES * MBX_PER_CORE,
  localparam int CTRL_W = 2 * MBX_PER_CORE,
  localparam int IDX_W  = $clog2(NMBX),
  localparam int CORE_W = $clog2(NUM_CORES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [NMBX-1:0]      mbox_pending,
  output logic [NMBX-1:0]      irq_src,
  output logic [NMBX-1:0]      fiq_src,
  output logic [NUM_CORES-1:0] core_irq,
  output logic [NUM_CORES-1:0] core_fiq
);
  import mbx_pkg::*;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Address decode
  win_e              win;
  logic [IDX_W-1:0]  idx;
  logic [CORE_W-1:0] core_sel;

  mbx_decode #(
    .ADDR_W(ADDR_W), .NMBX(NMBX), .NCORE(NUM_CORES),
    .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE), .CTRL_BASE(CTRL_BASE)
  ) u_dec (
    .addr(addr), .win(win), .idx(idx), .core_sel(core_sel)
  );

  // Mailbox storage
  logic [NMBX*DATA_W-1:0] mbox_flat;
  logic                   set_en, clr_en;

  assign set_en = wr_en && (win == WIN_SET);
  assign clr_en = wr_en && (win == WIN_CLR);

  mbx_store #(.NMBX(NMBX), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_int_n), .set_en(set_en), .clr_en(clr_en),
    .idx(idx), .wdata(wdata), .mbox_flat(mbox_flat)
  );

  for (genvar i = 0; i < NMBX; i++) begin : g_pend
    assign mbox_pending[i] = |mbox_flat[i*DATA_W +: DATA_W];
  end

  // Per-core delivery control registers
  logic [NUM_CORES*CTRL_W-1:0] ctrl_flat;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_ctrl
    logic [CTRL_W-1:0] ctrl_q, ctrl_d;
    logic              ctrl_en;

    always_comb begin
      ctrl_en = wr_en && (win == WIN_CTRL) && (core_sel == CORE_W'(c));
      ctrl_d  = wdata[CTRL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n)   ctrl_q <= '0;
      else if (ctrl_en) ctrl_q <= ctrl_d;
    end

    assign ctrl_flat[c*CTRL_W +: CTRL_W] = ctrl_q;
  end

  // Delivery routing
  mbx_route #(.NCORE(NUM_CORES), .MPC(MBX_PER_CORE)) u_route (
    .pending(mbox_pending), .ctrl_flat(ctrl_flat),
    .irq_src(irq_src), .fiq_src(fiq_src),
    .core_irq(core_irq), .core_fiq(core_fiq)
  );

  // Registered read port
  logic [DATA_W-1:0] rdata_q, rdata_d;

  always_comb begin
    unique case (win)
      WIN_CLR:  rdata_d = mbox_flat[idx*DATA_W +: DATA_W];
      WIN_CTRL: rdata_d = DATA_W'(ctrl_flat[core_sel*CTRL_W +: CTRL_W]);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rdata_q <= '0;
    else if (rd_en)  rdata_q <= rdata_d;
  end
  assign rdata = rdata_q;

endmodule

// File: rtl/mbx_bank_chk.sv
module mbx_bank_chk #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int NUM_CORES = 4,
  parameter int NMBX      = 16,
  parameter int SET_BASE  = 'h80,
  parameter int CLR_BASE  = 'hC0,
  localparam int IDX_W    = $clog2(NMBX)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    wdata,
  input logic [DATA_W-1:0]    rdata,
  input logic [NMBX-1:0]      mbox_pending,
  input logic [NMBX-1:0]      irq_src,
  input logic [NMBX-1:0]      fiq_src,
  input logic [NUM_CORES-1:0] core_irq,
  input logic [NUM_CORES-1:0] core_fiq
);

  logic [31:0]      a32;
  logic             in_set, in_clr;
  logic [IDX_W-1:0] set_idx, clr_idx;

  always_comb begin
    a32     = 32'(addr);
    in_set  = a32 >= 32'(SET_BASE) && a32 < 32'(SET_BASE + 4 * NMBX);
    in_clr  = a32 >= 32'(CLR_BASE) && a32 < 32'(CLR_BASE + 4 * NMBX);
    set_idx = IDX_W'((a32 - 32'(SET_BASE)) >> 2);
    clr_idx = IDX_W'((a32 - 32'(CLR_BASE)) >> 2);
  end

  assert_set_pends_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_set && wdata != '0) |=> mbox_pending[$past(set_idx)]);

  assert_full_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_clr && wdata == '1) |=> !mbox_pending[$past(clr_idx)]);

  assert_set_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && in_set) |=> rdata == '0);

  assert_src_needs_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_src | fiq_src) & ~mbox_pending) == '0);

  assert_fiq_excludes_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src & fiq_src) == '0);

  assert_core_line_needs_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|{core_irq, core_fiq}) |-> (|mbox_pending));

  assert_reset_clears_R10: assert property (@(posedge clk)
    !rst_n |-> (mbox_pending == '0 && irq_src == '0 && fiq_src == '0));

  assert_stable_without_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mbox_pending));

endmodule

bind mbx_bank mbx_bank_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CORES(NUM_CORES), .NMBX(NMBX),
  .SET_BASE(SET_BASE), .CLR_BASE(CLR_BASE)
) u_chk (.*);

// File: tb/tb_mbx_bank.sv
module tb_mbx_bank;

  logic        clk, rst_n, wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [15:0] mbox_pending, irq_src, fiq_src;
  logic [3:0]  core_irq, core_fiq;

  mbx_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .mbox_pending(mbox_pending),
    .irq_src(irq_src), .fiq_src(fiq_src), .core_irq(core_irq), .core_fiq(core_fiq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0, errors = 0;

  // Reference model
  logic [31:0] mb [16];
  logic [7:0]  ctl [4];

  // Scoreboard for read results
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen = 1'b0;

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic model_clear();
    for (int i = 0; i < 16; i++) mb[i] = '0;
    for (int c = 0; c < 4; c++) ctl[c] = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    if (a >= 8'hC0)                  mb[(a - 8'hC0) >> 2] &= ~d;
    else if (a >= 8'h80)             mb[(a - 8'h80) >> 2] |= d;
    else if (a >= 8'h50 && a < 8'h60) ctl[(a - 8'h50) >> 2] = d[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic check_vec(input string t, input string what,
                           input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s actual %h expected %h", t, what, act, exp);
    end
  endtask

  task automatic check_outputs(input string t);
    logic [15:0] pe, ie, fe;
    logic [3:0]  ci, cf;
    ci = '0; cf = '0;
    for (int i = 0; i < 16; i++) begin
      int c, n;
      c = i / 4; n = i % 4;
      pe[i] = (mb[i] != 0);
      fe[i] = pe[i] && ctl[c][4+n];
      ie[i] = pe[i] && !ctl[c][4+n] && ctl[c][n];
      ci[c] = ci[c] | ie[i];
      cf[c] = cf[c] | fe[i];
    end
    check_vec(t, "mbox_pending", mbox_pending, pe);
    check_vec(t, "irq_src", irq_src, ie);
    check_vec(t, "fiq_src", fiq_src, fe);
    check_vec(t, "core_irq/core_fiq", {8'h00, ci, cf}, {8'h00, core_irq, core_fiq});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    check_outputs("R10 reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    do_reset();
    rd(8'hC0, 32'h0, "R10 mailbox after reset");
    rd(8'h50, 32'h0, "R10 control after reset");

    // R6: only eight bits stored
    wr(8'h50, 32'h0000_012F);
    rd(8'h50, 32'h0000_002F, "R6 control truncation");

    // R1/R8: set core0 mb0, routed to normal interrupt
    wr(8'h80, 32'h0000_0005);
    check_outputs("R1 R8 first set");
    wr(8'h80, 32'h0000_00A0);
    rd(8'hC0, 32'h0000_00A5, "R1 OR accumulate");

    // R7: core0 mb1 has both enables; fast wins
    wr(8'h84, 32'h0000_0001);
    check_outputs("R7 fiq priority");

    // R4: set window reads zero
    rd(8'h80, 32'h0, "R4 set window read");

    // R2: partial then full clear
    wr(8'hC0, 32'h0000_0005);
    rd(8'hC0, 32'h0000_00A0, "R2 partial clear");
    check_outputs("R2 R5 still pending");
    wr(8'hC0, 32'h0000_00A0);
    check_outputs("R5 cleared to zero");

    // R8: masked mailbox core2 mb3 (index 11)
    wr(8'hAC, 32'h8000_0000);
    check_outputs("R8 masked pending");
    wr(8'h58, 32'h0000_0080);
    check_outputs("R9 core2 fast line");

    // R3: reads do not clear
    rd(8'hEC, 32'h8000_0000, "R3 first read");
    rd(8'hEC, 32'h8000_0000, "R3 second read");
    check_outputs("R3 after reads");

    // R12: unmapped write ignored
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    check_outputs("R12 unmapped write");
    rd(8'h50, 32'h0000_002F, "R12 control unchanged");

    // R11: idle cycles leave outputs steady
    repeat (4) @(negedge clk);
    check_outputs("R11 idle");

    // Several mailboxes on core3 with mixed routing
    wr(8'h5C, 32'h0000_0093);
    wr(8'hB0, 32'h0000_0001);
    wr(8'hB4, 32'h0000_0002);
    wr(8'hBC, 32'h0000_0004);
    check_outputs("R9 core3 mixed");

    // R10: reset while loaded
    do_reset();
    rd(8'hFC, 32'h0, "R10 mailbox cleared");
    rd(8'h5C, 32'h0, "R10 control cleared");
    check_outputs("R10 after release");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending reads expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule